// File: doc/BRIEF.md
# Selection Timeout Timer

This block bounds the time a bus-selection attempt may wait for the addressed target to answer. Software programs an 8-bit period value; each unit of that value stands for a fixed block of input clock cycles (80,000 by default, a parameter). The count of clock cycles per unit is chosen so that the host computes the register value from the wanted time in milliseconds and the input clock rate, and then adds one unit of margin.

When a selection starts, a prescaler and a period counter are cleared and begin counting. If the target answers, or the attempt is cancelled, the timer stops quietly. If the programmed number of units passes first, the block raises its interrupt flag and presents the terminated-class status code 0x42. It holds both until the host acknowledges. A 2-bit clock-range field is decoded into a one-hot band indication for the neighbouring selection logic.

Top module: `sel_timeout_timer`

## Requirements
- R1: After reset, active_o is 0, irq_o is 0 and status_o reads 0x00, which is the reset cause code.
- R2: With no answer and no cancel, irq_o rises and status_o becomes 0x42 exactly UNIT_CYCLES × P clock edges after the edge that samples sel_start_i. P is the effective period. In 0x42 the upper nibble 0x4 is the error cause and the lower nibble 0x2 is the timeout qualifier.
- R3: A period value of 0 gives an effective period of 1 unit. Any other value is used as given.
- R4: A sel_resp_i pulse sampled while active, up to and including the edge on which expiry would occur, stops the timer with no interrupt and no code.
- R5: A sel_cancel_i pulse behaves like a response: it stops the timer with no interrupt and no code.
- R6: Once raised, irq_o and status_o 0x42 hold until irq_ack_i is sampled. Acknowledging then returns irq_o to 0 and status_o to 0x00. An acknowledge with no pending interrupt has no effect.
- R7: sel_start_i sampled while the timer is already running clears both counters, so expiry is counted afresh from the new start edge.
- R8: period_i is captured on the start edge. Changes made to it while the timer runs do not move the expiry point.
- R9: band_o is one-hot: bit 0 means 8–10 MHz (code 00), bit 1 means 12–15 MHz (code 01), bit 2 means 16–20 MHz (code 10). The reserved code 11 decodes like 00.
- R10: If expiry and irq_ack_i fall on the same edge, the expiry wins and irq_o stays 1.
- R11: active_o is 1 from the edge after a start until the edge that sees expiry, response or cancel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | PERIOD_W | Timeout period in units |
| clk_range_i | input | 2 | Input clock band code |
| sel_start_i | input | 1 | Begin (or restart) timing a selection |
| sel_resp_i | input | 1 | Target answered |
| sel_cancel_i | input | 1 | Abandon the selection attempt |
| irq_ack_i | input | 1 | Host acknowledge of the timeout interrupt |
| active_o | output | 1 | Timer is running |
| irq_o | output | 1 | Timeout interrupt pending |
| status_o | output | 8 | Status code: 0x00 idle/reset, 0x42 selection timeout |
| band_o | output | 3 | One-hot decoded clock band |

## Verification
The bench sets the cycles-per-unit parameter small, so that every expiry edge can be checked cycle by cycle. Its corner cases are these:
- A zero period. A design that loads it literally would wait 256 units or never fire.
- A response on the very edge of expiry. A design with the wrong priority would raise a false timeout.
- A restart in the middle of a run. A design that fails to clear the prescaler would fire early.
- A period changed after the start. A design that does not latch the period would move the expiry point.
- An acknowledge on the same edge as expiry. A design that gives the acknowledge priority would lose the interrupt.

The bench also checks the reserved clock-range code, which must decode to the lowest band.

// File: rtl/sto_pkg.sv
package sto_pkg;

   localparam logic [7:0] STS_IDLE    = 8'h00;
   localparam logic [7:0] STS_SEL_TMO = 8'h42;

   typedef enum logic [1:0] {
      BAND_LOW  = 2'b00,
      BAND_MID  = 2'b01,
      BAND_HIGH = 2'b10,
      BAND_RSVD = 2'b11
   } band_code_e;

   function automatic logic [2:0] band_decode(input logic [1:0] code);
      logic [2:0] r;
      case (band_code_e'(code))
         BAND_MID:  r = 3'b010;
         BAND_HIGH: r = 3'b100;
         default:   r = 3'b001;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sto_prescaler.sv
module sto_prescaler #(
   parameter int UNIT_CYCLES = 80000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);
   localparam int PW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
   localparam logic [PW-1:0] LAST = PW'(UNIT_CYCLES - 1);

   if (UNIT_CYCLES < 1) begin : g_bad
      $error("sto_prescaler: UNIT_CYCLES must be at least 1");
   end

   if (UNIT_CYCLES == 1) begin : g_direct
      assign tick = run && !clr;
   end else begin : g_count
      logic [PW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt <= '0;
         else if (clr)    cnt <= '0;
         else if (run)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
      assign tick = run && !clr && (cnt == LAST);
   end

endmodule

// File: rtl/sto_period_ctr.sv
module sto_period_ctr #(
   parameter int PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [PERIOD_W-1:0] period,
   input  logic                tick,
   output logic                done
);
   if (PERIOD_W < 1) begin : g_bad
      $error("sto_period_ctr: PERIOD_W must be at least 1");
   end

   logic [PERIOD_W-1:0] lim;
   logic [PERIOD_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim <= PERIOD_W'(1);
         cnt <= '0;
      end else if (load) begin
         lim <= (period == '0) ? PERIOD_W'(1) : period;
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done = tick && !load && (cnt == lim - 1'b1);

endmodule

// File: rtl/sto_status.sv
module sto_status
   import sto_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set,
   input  logic       ack,
   output logic       irq,
   output logic [7:0] code
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq  <= 1'b0;
         code <= STS_IDLE;
      end else if (set) begin
         irq  <= 1'b1;
         code <= STS_SEL_TMO;
      end else if (ack) begin
         irq  <= 1'b0;
         code <= STS_IDLE;
      end
   end
endmodule

// File: rtl/sel_timeout_timer.sv
module sel_timeout_timer
   import sto_pkg::*;
#(
   parameter int UNIT_CYCLES = 80000,
   parameter int PERIOD_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] period_i,
   input  logic [1:0]          clk_range_i,
   input  logic                sel_start_i,
   input  logic                sel_resp_i,
   input  logic                sel_cancel_i,
   input  logic                irq_ack_i,
   output logic                active_o,
   output logic                irq_o,
   output logic [7:0]          status_o,
   output logic [2:0]          band_o
);
   logic run_q;
   logic tick;
   logic done_raw;
   logic stop_req;
   logic expire;

   assign stop_req = run_q && (sel_resp_i || sel_cancel_i);
   assign expire   = run_q && done_raw && !sel_start_i && !stop_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_q <= 1'b0;
      else if (sel_start_i) run_q <= 1'b1;
      else if (stop_req)    run_q <= 1'b0;
      else if (expire)      run_q <= 1'b0;
   end

   sto_prescaler #(.UNIT_CYCLES(UNIT_CYCLES)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(sel_start_i), .run(run_q), .tick(tick)
   );

   sto_period_ctr #(.PERIOD_W(PERIOD_W)) u_period (
      .clk(clk), .rst_n(rst_n), .load(sel_start_i), .period(period_i),
      .tick(tick), .done(done_raw)
   );

   sto_status u_stat (
      .clk(clk), .rst_n(rst_n), .set(expire), .ack(irq_ack_i),
      .irq(irq_o), .code(status_o)
   );

   assign active_o = run_q;
   assign band_o   = band_decode(clk_range_i);

endmodule

// File: rtl/sel_timeout_timer_chk.sv
module sel_timeout_timer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_start_i,
   input logic       sel_resp_i,
   input logic       sel_cancel_i,
   input logic       irq_ack_i,
   input logic       active_o,
   input logic       irq_o,
   input logic [7:0] status_o,
   input logic [2:0] band_o
);
   assert_code_on_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> status_o == 8'h42);

   assert_only_two_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      status_o == 8'h00 || status_o == 8'h42);

   assert_irq_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && !irq_ack_i |=> irq_o);

   assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack_i && !active_o |=> !irq_o && status_o == 8'h00);

   assert_stop_on_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      active_o && (sel_resp_i || sel_cancel_i) && !sel_start_i |=> !active_o);

   assert_no_irq_after_answer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      active_o && (sel_resp_i || sel_cancel_i) && !sel_start_i && !irq_o |=> !irq_o);

   assert_start_runs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sel_start_i |=> active_o);

   assert_band_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(band_o) == 1);
endmodule

bind sel_timeout_timer sel_timeout_timer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sel_start_i(sel_start_i), .sel_resp_i(sel_resp_i),
   .sel_cancel_i(sel_cancel_i), .irq_ack_i(irq_ack_i), .active_o(active_o),
   .irq_o(irq_o), .status_o(status_o), .band_o(band_o)
);

// File: tb/sel_timeout_timer_test.sv
`timescale 1ns/1ps
module sel_timeout_timer_test;
   localparam int U = 6;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] period_i = '0;
   logic [1:0]    clk_range_i = 2'b00;
   logic          sel_start_i = 1'b0, sel_resp_i = 1'b0, sel_cancel_i = 1'b0, irq_ack_i = 1'b0;
   logic          active_o, irq_o;
   logic [7:0]    status_o;
   logic [2:0]    band_o;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sel_timeout_timer #(.UNIT_CYCLES(U), .PERIOD_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .clk_range_i(clk_range_i),
      .sel_start_i(sel_start_i), .sel_resp_i(sel_resp_i), .sel_cancel_i(sel_cancel_i),
      .irq_ack_i(irq_ack_i), .active_o(active_o), .irq_o(irq_o),
      .status_o(status_o), .band_o(band_o)
   );

   function automatic int eff_period(input int p);
      return (p == 0) ? 1 : p;
   endfunction

   function automatic logic [2:0] exp_band(input logic [1:0] c);
      return (c == 2'b01) ? 3'b010 : (c == 2'b10) ? 3'b100 : 3'b001;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step;
      @(negedge clk);
   endtask

   task automatic clear_irq;
      irq_ack_i = 1'b1; step(); irq_ack_i = 1'b0; step();
   endtask

   // resp_at: edge of answer/cancel (0 none); restart_at: second start (0 none);
   // ack_at: edge of acknowledge (0 none). Edge 0 is the first start.
   task automatic run_case(input string req, input int p, input int resp_at,
                           input bit use_cancel, input int restart_at, input int ack_at);
      int base, t_exp, stop_at, last, bad_t;
      bit fires;
      logic [2:0] got, want;
      base    = restart_at;
      t_exp   = base + U * eff_period(p);
      fires   = !(resp_at > base && resp_at <= t_exp);
      stop_at = fires ? t_exp : resp_at;
      last    = t_exp + 3;
      bad_t   = -1;
      got = '0; want = '0;
      period_i = PW'(p);
      sel_start_i = 1'b1;
      step();
      sel_start_i = 1'b0;
      period_i = PW'($urandom_range(1, 200));  // R8: later changes must not matter
      for (int t = 1; t <= last; t++) begin
         bit e_irq, e_act;
         sel_start_i  = (t == restart_at);
         if (t == restart_at) period_i = PW'(p);
         sel_resp_i   = (t == resp_at) && !use_cancel;
         sel_cancel_i = (t == resp_at) && use_cancel;
         irq_ack_i    = (t == ack_at);
         step();
         if (t == restart_at) period_i = PW'($urandom_range(1, 200));
         e_irq = fires && t >= t_exp && !(ack_at > t_exp && t >= ack_at);
         e_act = t < stop_at;
         if (bad_t < 0 && (irq_o !== e_irq || active_o !== e_act ||
             status_o !== (e_irq ? 8'h42 : 8'h00))) begin
            bad_t = t;
            got  = {active_o, irq_o, status_o == 8'h42};
            want = {e_act, e_irq, e_irq};
         end
      end
      sel_start_i = 0; sel_resp_i = 0; sel_cancel_i = 0; irq_ack_i = 0;
      if (bad_t >= 0) $display("  mismatch at edge %0d of case %s (act,irq,code)", bad_t, req);
      check(req, got, want);
      clear_irq();
   endtask

   initial begin
      repeat (3) step();
      check("R1 active", active_o, 0);
      check("R1 irq", irq_o, 0);
      check("R1 status", status_o, 8'h00);
      rst_n = 1'b1;
      step();

      for (int c = 0; c < 4; c++) begin
         clk_range_i = 2'(c);
         step();
         check("R9 band decode", band_o, exp_band(2'(c)));
      end

      run_case("R2 plain expiry p=3", 3, 0, 0, 0, 0);
      run_case("R2 p=1", 1, 0, 0, 0, 0);
      run_case("R3 zero period", 0, 0, 0, 0, 0);
      run_case("R4 early response", 4, 7, 0, 0, 0);
      run_case("R4 response on expiry edge", 2, 2 * U, 0, 0, 0);
      run_case("R4 response one after expiry", 2, 2 * U + 1, 0, 0, 0);
      run_case("R5 cancel", 3, 5, 1, 0, 0);
      run_case("R5 cancel on expiry edge", 1, U, 1, 0, 0);
      run_case("R6 ack releases", 2, 0, 0, 0, 2 * U + 2);
      run_case("R6 ack before expiry ignored", 2, 0, 0, 0, 3);
      run_case("R10 ack on expiry edge", 2, 0, 0, 0, 2 * U);
      run_case("R7 restart mid run", 2, 0, 0, U + 2, 0);
      run_case("R7 R11 restart then answer", 3, U + 9, 0, 4, 0);

      // R6: idle acknowledge leaves outputs unchanged
      irq_ack_i = 1'b1; step(); irq_ack_i = 1'b0;
      check("R6 idle ack", {irq_o, status_o}, 9'h000);

      for (int n = 0; n < 20; n++) begin
         int p, r;
         p = $urandom_range(0, 10);
         r = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, U * eff_period(p) + 2);
         run_case("R2 R4 R5 random", p, r, $urandom_range(0, 1), 0, 0);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule